// File: doc/BRIEF.md
# DMA Bus Hold Arbitration Controller

This block decides the cycle in which a pending DMA transfer may begin on a small controller whose external memory bus is shared with another bus master. It watches a request line from the DMA source and a strobe from the instruction sequencer that marks the last machine cycle of each instruction. When an instruction boundary is reached, it holds the sequencer for the whole transfer. Before it issues the start pulse, it runs whichever bus handshake software has enabled.

Software enables two handshake roles independently. In requester mode the block raises its own hold request and waits for the partner's acknowledge. In arbiter mode it grants the bus to an outside master that asks for it, and it keeps its own external transfers back while that grant is active. Only transfers marked as touching external RAM wait for a handshake. Transfers between internal memories start at the boundary whatever the mode. The block produces only control strobes: addresses, data, byte counts and memory strobes belong to neighbouring logic.

Top module: `dma_hold_arb`

## Requirements
- R1: A request held high in a cycle before the instruction's last-cycle strobe produces a single-cycle `dma_start` in the cycle right after that strobe, when no handshake is needed.
- R2: A request first seen in the same cycle as the last-cycle strobe is not taken at that boundary. It starts in the cycle after the next last-cycle strobe.
- R3: `cpu_stall` is low in the boundary cycle. It is high from the next cycle through the cycle in which `dma_done` is high, and low again in the cycle after that.
- R4: A transfer with `dma_ext` low never waits for a handshake. It starts right after its boundary in every mode, leaves `hold_req_out` low and leaves an active `hold_ack_out` unchanged.
- R5: In requester mode, an external transfer raises `hold_req_out` one cycle after the stall begins. `dma_start` is issued only in a cycle where `hold_ack_in` is high.
- R6: In requester mode, `hold_req_out` stays high through the cycle in which `dma_done` is high and drops in the next cycle.
- R7: In requester mode, `hold_req_out` is not raised again while `hold_ack_in` is still high from the previous grant. It rises two cycles after `hold_ack_in` goes low.
- R8: In arbiter mode, `hold_ack_out` follows `hold_req_in` one cycle later while no external transfer is running.
- R9: In arbiter mode, an external transfer does not start while `hold_req_in` or `hold_ack_out` is high. The outside request wins when both arrive together, and the transfer starts in the first cycle where both are low.
- R10: In arbiter mode, an outside request that rises during an external transfer is acknowledged only after the transfer ends: `hold_ack_out` is high two cycles after the `dma_done` cycle.
- R11: With both modes off, an external transfer starts by the boundary rule alone, and `hold_ack_out` stays low even when `hold_req_in` is high.
- R12: While `rst_n` is low, `dma_start`, `cpu_stall`, `hold_req_out` and `hold_ack_out` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mode_req_en | input | 1 | Enables the requester handshake role |
| mode_arb_en | input | 1 | Enables the arbiter handshake role |
| dma_req | input | 1 | DMA transfer request, held until the start pulse |
| dma_ext | input | 1 | Request touches external RAM; captured at the boundary |
| last_cyc | input | 1 | Last machine cycle of the current instruction |
| dma_done | input | 1 | Current transfer finishes in this cycle |
| hold_ack_in | input | 1 | Acknowledge from the partner (requester mode) |
| hold_req_in | input | 1 | Hold request from an outside master (arbiter mode) |
| dma_start | output | 1 | Single-cycle start pulse for the transfer engine |
| cpu_stall | output | 1 | Freezes the instruction sequencer |
| hold_req_out | output | 1 | Hold request to the partner (requester mode) |
| hold_ack_out | output | 1 | Grant to the outside master (arbiter mode) |

## Verification
A state register stuck in the waiting or transfer state shows at once as `cpu_stall` staying high past the cycle after `dma_done`. A lost boundary flag shows as a start pulse one instruction late. A release flag that never clears shows as `hold_req_out` staying low two cycles after the acknowledge has dropped. A wrong arbiter grant shows within one cycle, either as a start pulse while the outside master holds the bus or as `hold_ack_out` rising during an external transfer. The bench checks each of these ports in the exact cycle the requirements give.

// File: rtl/dha_pkg.sv
package dha_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_XFER = 2'd2
   } dha_state_e;

   localparam int DHA_MAX_SYNC = 4;
endpackage

// File: rtl/dha_boundary.sv
// Instruction-boundary tracker: a request must already be present in a
// cycle before the last-cycle strobe to be taken at that boundary.
module dha_boundary (
   input  logic clk,
   input  logic rst_n,
   input  logic idle,
   input  logic dma_req,
   input  logic last_cyc,
   output logic fire
);
   logic seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen_q <= 1'b0;
      else        seen_q <= idle & dma_req;
   end

   assign fire = idle & dma_req & seen_q & last_cyc;
endmodule

// File: rtl/dha_requester.sv
// Requester role: raise hold, keep it through the transfer, then wait for
// the partner to drop its acknowledge before asking again.
module dha_requester (
   input  logic clk,
   input  logic rst_n,
   input  logic in_wait,
   input  logic want,
   input  logic xfer_end,
   input  logic ack_in,
   output logic hold_req,
   output logic granted
);
   logic rel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rel_q    <= 1'b0;
         hold_req <= 1'b0;
      end else begin
         if (xfer_end && hold_req) rel_q <= 1'b1;
         else if (!ack_in)         rel_q <= 1'b0;

         if (xfer_end)                        hold_req <= 1'b0;
         else if (in_wait && !want)           hold_req <= 1'b0;
         else if (want && !rel_q && !hold_req) hold_req <= 1'b1;
      end
   end

   assign granted = hold_req & ack_in;
endmodule

// File: rtl/dha_arbiter.sv
// Arbiter role: grant the bus to an outside master unless an external
// transfer of our own already holds it.
module dha_arbiter (
   input  logic clk,
   input  logic rst_n,
   input  logic arb_en,
   input  logic hreq_in,
   input  logic ext_busy,
   output logic hold_ack,
   output logic clear
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hold_ack <= 1'b0;
      else        hold_ack <= arb_en & hreq_in & ~ext_busy;
   end

   // The outside request wins a same-cycle tie: it blocks start directly.
   assign clear = ~arb_en | (~hreq_in & ~hold_ack);
endmodule

// File: rtl/dma_hold_arb.sv
module dma_hold_arb
   import dha_pkg::*;
#(
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mode_req_en,
   input  logic mode_arb_en,
   input  logic dma_req,
   input  logic dma_ext,
   input  logic last_cyc,
   input  logic dma_done,
   input  logic hold_ack_in,
   input  logic hold_req_in,
   output logic dma_start,
   output logic cpu_stall,
   output logic hold_req_out,
   output logic hold_ack_out
);
   localparam int NSIG = 2;

   logic [NSIG-1:0] hs_raw;
   logic [NSIG-1:0] hs_syn;
   logic            ack_s;
   logic            hreq_s;

   assign hs_raw = {hold_ack_in, hold_req_in};

   generate
      if (SYNC_STAGES < 0 || SYNC_STAGES > DHA_MAX_SYNC) begin : g_bad
         $error("dma_hold_arb: SYNC_STAGES out of range");
      end
      if (SYNC_STAGES == 0) begin : g_nosync
         assign hs_syn = hs_raw;
      end else begin : g_sync
         logic [NSIG-1:0] pipe_q [SYNC_STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < SYNC_STAGES; i++) pipe_q[i] <= '0;
            end else begin
               pipe_q[0] <= hs_raw;
               for (int i = 1; i < SYNC_STAGES; i++) pipe_q[i] <= pipe_q[i-1];
            end
         end
         assign hs_syn = pipe_q[SYNC_STAGES-1];
      end
   endgenerate

   assign ack_s  = hs_syn[1];
   assign hreq_s = hs_syn[0];

   dha_state_e state_q, state_d;
   logic ext_q;
   logic idle_w, wait_w, xfer_w;
   logic boundary, want, xfer_end, ext_busy;
   logic req_grant, arb_clear, ext_ok;

   assign idle_w   = (state_q == ST_IDLE);
   assign wait_w   = (state_q == ST_WAIT);
   assign xfer_w   = (state_q == ST_XFER);
   assign want     = wait_w & ext_q & mode_req_en;
   assign xfer_end = xfer_w & dma_done;
   assign ext_busy = xfer_w & ext_q;

   dha_boundary u_bnd (
      .clk      (clk),
      .rst_n    (rst_n),
      .idle     (idle_w),
      .dma_req  (dma_req),
      .last_cyc (last_cyc),
      .fire     (boundary)
   );

   dha_requester u_req (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_wait  (wait_w),
      .want     (want),
      .xfer_end (xfer_end),
      .ack_in   (ack_s),
      .hold_req (hold_req_out),
      .granted  (req_grant)
   );

   dha_arbiter u_arb (
      .clk      (clk),
      .rst_n    (rst_n),
      .arb_en   (mode_arb_en),
      .hreq_in  (hreq_s),
      .ext_busy (ext_busy),
      .hold_ack (hold_ack_out),
      .clear    (arb_clear)
   );

   assign ext_ok    = ~ext_q | ((~mode_req_en | req_grant) & arb_clear);
   assign dma_start = wait_w & ext_ok;
   assign cpu_stall = ~idle_w;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (boundary)  state_d = ST_WAIT;
         ST_WAIT: if (dma_start) state_d = ST_XFER;
         ST_XFER: if (dma_done)  state_d = ST_IDLE;
         default:                state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         ext_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         if (boundary) ext_q <= dma_ext;
      end
   end
endmodule

// File: rtl/dha_hold_arb_chk.sv
module dha_hold_arb_chk (
   input logic clk,
   input logic rst_n,
   input logic mode_req_en,
   input logic mode_arb_en,
   input logic dma_done,
   input logic ext_q,
   input logic ack_s,
   input logic hreq_s,
   input logic dma_start,
   input logic cpu_stall,
   input logic hold_req_out,
   input logic hold_ack_out
);
   p_start_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
      dma_start |=> !dma_start);

   p_start_stalled_r3: assert property (@(posedge clk) disable iff (!rst_n)
      dma_start |-> cpu_stall);

   p_req_granted_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_start && ext_q && mode_req_en) |-> (hold_req_out && ack_s));

   p_req_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_req_out && mode_req_en && !dma_done) |=> hold_req_out);

   p_arb_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_start && ext_q && mode_arb_en) |-> (!hreq_s && !hold_ack_out));

   p_ack_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_arb_en |=> !hold_ack_out);
endmodule

bind dma_hold_arb dha_hold_arb_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .mode_req_en  (mode_req_en),
   .mode_arb_en  (mode_arb_en),
   .dma_done     (dma_done),
   .ext_q        (ext_q),
   .ack_s        (ack_s),
   .hreq_s       (hreq_s),
   .dma_start    (dma_start),
   .cpu_stall    (cpu_stall),
   .hold_req_out (hold_req_out),
   .hold_ack_out (hold_ack_out)
);

// File: tb/dma_hold_arb_bench.sv
module dma_hold_arb_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mode_req_en = 0, mode_arb_en = 0, dma_req = 0, dma_ext = 0;
   logic last_cyc = 0, dma_done = 0, hold_ack_in = 0, hold_req_in = 0;
   logic dma_start, cpu_stall, hold_req_out, hold_ack_out;

   int cyc = 0;
   int n_chk = 0;
   int n_err = 0;
   bit finished = 0;

   typedef struct { int when; string tag; } exp_t;
   exp_t exp_q[$];

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   dma_hold_arb u_dma_hold_arb (
      .clk(clk), .rst_n(rst_n), .mode_req_en(mode_req_en), .mode_arb_en(mode_arb_en),
      .dma_req(dma_req), .dma_ext(dma_ext), .last_cyc(last_cyc), .dma_done(dma_done),
      .hold_ack_in(hold_ack_in), .hold_req_in(hold_req_in), .dma_start(dma_start),
      .cpu_stall(cpu_stall), .hold_req_out(hold_req_out), .hold_ack_out(hold_ack_out)
   );

   task automatic chk(input logic act, input logic expv, input string tag);
      n_chk++;
      if (act !== expv) begin
         n_err++;
         $display("FAIL %s: cycle %0d actual=%b expected=%b", tag, cyc, act, expv);
      end
   endtask

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic settle();
      #3;
   endtask

   task automatic expect_start(input int when, input string tag);
      exp_t e;
      e.when = when; e.tag = tag;
      exp_q.push_back(e);
   endtask

   // Monitor: every start pulse is compared with the oldest expected item.
   always @(negedge clk) begin
      if (rst_n && dma_start) begin
         n_chk++;
         if (exp_q.size() == 0) begin
            n_err++;
            $display("FAIL R1: unexpected start at cycle %0d actual=1 expected=0", cyc);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            if (e.when != cyc) begin
               n_err++;
               $display("FAIL %s: start at cycle %0d expected cycle %0d", e.tag, cyc, e.when);
            end
         end
      end
   end

   // Called in the start cycle: runs the transfer for len cycles, then ends it.
   task automatic finish(input int len, input logic hold_exp, input string tag);
      dma_req = 0;
      repeat (len) step();
      dma_done = 1;
      settle();
      chk(cpu_stall, 1'b1, "R3 stall in done cycle");
      chk(hold_req_out, hold_exp, {tag, " hold during done cycle"});
      step();
      dma_done = 0;
      settle();
      chk(cpu_stall, 1'b0, "R3 stall released");
      chk(hold_req_out, 1'b0, {tag, " hold released"});
      step();
   endtask

   int c0;

   initial begin
      // R12: reset state
      repeat (3) @(posedge clk);
      #4;
      chk(dma_start, 1'b0, "R12 start in reset");
      chk(cpu_stall, 1'b0, "R12 stall in reset");
      chk(hold_req_out, 1'b0, "R12 hold_req in reset");
      chk(hold_ack_out, 1'b0, "R12 hold_ack in reset");
      rst_n = 1;
      step(); step();

      // R1 / R4: internal transfer, requester mode on, no handshake
      mode_req_en = 1;
      c0 = cyc;
      dma_req = 1; dma_ext = 0;
      expect_start(c0 + 2, "R1");
      step(); last_cyc = 1;
      settle();
      chk(cpu_stall, 1'b0, "R3 no stall in boundary cycle");
      step(); last_cyc = 0;
      settle();
      chk(cpu_stall, 1'b1, "R3 stall in start cycle");
      chk(hold_req_out, 1'b0, "R4 no hold for internal");
      finish(2, 1'b0, "R4");
      mode_req_en = 0;

      // R2: request first seen in the last cycle waits one instruction
      c0 = cyc;
      dma_req = 1; dma_ext = 0; last_cyc = 1;
      step(); last_cyc = 0;
      settle();
      chk(dma_start, 1'b0, "R2 no start after late request");
      chk(cpu_stall, 1'b0, "R2 no stall after late request");
      step(); step();
      last_cyc = 1;
      expect_start(c0 + 4, "R2");
      step(); last_cyc = 0;
      settle();
      finish(1, 1'b0, "R2");

      // R5 / R6: requester handshake
      mode_req_en = 1;
      c0 = cyc;
      dma_req = 1; dma_ext = 1;
      step(); last_cyc = 1;
      step(); last_cyc = 0;
      settle();
      chk(dma_start, 1'b0, "R5 no start without ack");
      chk(hold_req_out, 1'b0, "R5 hold not yet raised");
      step(); settle();
      chk(hold_req_out, 1'b1, "R5 hold raised");
      chk(dma_start, 1'b0, "R5 still waiting for ack");
      step(); step();
      hold_ack_in = 1;
      expect_start(c0 + 5, "R5");
      settle();
      finish(3, 1'b1, "R6");

      // R7: no new hold request while the old acknowledge is still high
      dma_req = 1; dma_ext = 1;
      step(); last_cyc = 1;
      step(); last_cyc = 0;
      step(); step(); settle();
      chk(hold_req_out, 1'b0, "R7 no re-raise while ack high");
      chk(dma_start, 1'b0, "R7 no start while ack stale");
      step();
      hold_ack_in = 0;
      step(); settle();
      chk(hold_req_out, 1'b0, "R7 one cycle after ack drop");
      step(); settle();
      chk(hold_req_out, 1'b1, "R7 hold re-raised");
      step();
      hold_ack_in = 1;
      expect_start(cyc, "R7");
      settle();
      finish(1, 1'b1, "R6");
      hold_ack_in = 0;
      mode_req_en = 0;
      step(); step();

      // R8 / R9 / R10: arbiter mode
      mode_arb_en = 1;
      c0 = cyc;
      hold_req_in = 1; dma_req = 1; dma_ext = 1;
      settle();
      chk(hold_ack_out, 1'b0, "R8 ack not before request");
      step(); last_cyc = 1;
      settle();
      chk(hold_ack_out, 1'b1, "R8 ack one cycle after request");
      step(); last_cyc = 0;
      settle();
      chk(dma_start, 1'b0, "R9 outside request wins");
      step(); step(); step();
      hold_req_in = 0;
      settle();
      chk(dma_start, 1'b0, "R9 blocked while ack still high");
      step();
      expect_start(c0 + 6, "R9");
      settle();
      chk(hold_ack_out, 1'b0, "R8 ack dropped");
      dma_req = 0;
      step();
      hold_req_in = 1;
      step(); settle();
      chk(hold_ack_out, 1'b0, "R10 no ack during external transfer");
      step();
      dma_done = 1;
      step();
      dma_done = 0;
      settle();
      chk(hold_ack_out, 1'b0, "R10 ack not in cycle after done");
      step(); settle();
      chk(hold_ack_out, 1'b1, "R10 ack after transfer");

      // R4: internal transfer proceeds while the outside master holds the bus
      dma_req = 1; dma_ext = 0;
      expect_start(cyc + 2, "R4");
      step(); last_cyc = 1;
      step(); last_cyc = 0;
      settle();
      chk(hold_ack_out, 1'b1, "R4 grant kept during internal transfer");
      finish(1, 1'b0, "R4");
      hold_req_in = 0;
      mode_arb_en = 0;
      step(); step();

      // R11: neither mode
      hold_req_in = 1;
      dma_req = 1; dma_ext = 1;
      expect_start(cyc + 2, "R11");
      step(); last_cyc = 1;
      step(); last_cyc = 0;
      settle();
      chk(hold_ack_out, 1'b0, "R11 no ack with modes off");
      chk(hold_req_out, 1'b0, "R11 no hold with modes off");
      finish(1, 1'b0, "R11");
      hold_req_in = 0;
      step(); step();

      n_chk++;
      if (exp_q.size() != 0) begin
         n_err++;
         $display("FAIL R1: %0d expected starts never seen actual=0 expected=%0d",
                  exp_q.size(), exp_q.size());
      end
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: run did not complete actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule